// File: doc/BRIEF.md
# Dual-Mode Compare-Match PWM Timer

This block is one timer channel built around a free-running up-counter and four compare registers, each with its own 4-bit output-control field. When the counter equals a compare register, that register's control field picks what happens to the output pin it feeds: drive low, drive high, toggle, or leave the pin alone. Any of the four registers can be chosen as the source that clears the counter. This sets the PWM period.

Two pin mappings are selected by a single mode input. In paired mode, registers 0 and 1 together shape pin 0, and registers 2 and 3 together shape pin 2. Pins 1 and 3 stay low. In period mode, the register picked by the clear select is the period register. Each of the other three registers drives its own pin, and every one of those pins falls back to its initial level when the period match occurs. The period register's own pin stays low. In both mappings, two values that form one waveform and are equal cause no pin change on their matches. The counter is enabled by a run input. While it is stopped, and on any change of mode, the pins load their initial levels.

Top module: `cmp_pwm_timer`

## Requirements
- R1: While `run` is high the counter advances by one per clock and wraps from all ones to zero. While `run` is low it holds its value. Reset sets the counter and all pins to 0, every compare register to all ones and every control field to 0.
- R2: When `run` and `clr_en` are high and the counter equals compare register `clr_sel`, the counter is 0 on the next clock instead of advancing.
- R3: Control field bits [1:0] give the action on a match: 00 no change, 01 drive low, 10 drive high, 11 toggle. Bit 2 is the pin's initial level. Bit 3 has no effect. A pin changes on the clock edge that ends the cycle in which the counter equals the register.
- R4: With `mode` = 0, pin 0 takes the action of register 0 on a register-0 match and the action of register 1 on a register-1 match. Pin 2 is driven the same way by registers 2 and 3.
- R5: With `mode` = 0, pins 1 and 3 are low.
- R6: With `mode` = 1, each register other than `clr_sel` applies its own action to the pin of the same index on its match.
- R7: With `mode` = 1, a match on register `clr_sel` sets every other pin to its initial level (bit 2 of its field).
- R8: With `mode` = 1, the pin whose index equals `clr_sel` is low.
- R9: When the two values that shape one waveform are equal (registers 0/1 or 2/3 in mode 0; a duty register and the period register in mode 1), their matches leave that pin unchanged.
- R10: While `run` is low, and on the first clock after `mode` changes, every pin loads its initial level. In mode 0 this is bit 2 of the field of register 0 or 2 for pins 0 and 2, and low for pins 1 and 3. In mode 1 it is bit 2 of its own field, except that the period pin is low.
- R11: A write with `wr_addr[2]` = 0 loads compare register `wr_addr[1:0]` with `wr_data`. A write with `wr_addr[2]` = 1 loads control field `wr_addr[1:0]` with `wr_data[3:0]`. The new value is used from the next clock.
- R12: In mode 1, a duty value the counter never reaches keeps its pin at the initial level. This gives 0 % (initial level low) or 100 % (initial level high) duty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| run | input | 1 | Counter enable |
| mode | input | 1 | 0 = paired mapping, 1 = period mapping |
| clr_en | input | 1 | Enables counter clearing on a match |
| clr_sel | input | 2 | Clear-source / period register index |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Bit 2 picks control field vs compare register; bits 1:0 pick the index |
| wr_data | input | W | Write data |
| count | output | W | Counter value |
| pin | output | 4 | PWM pin levels |

## Verification
The paired mapping is run with distinct rise and fall values. Set, clear and toggle actions with different initial levels tell a pair's two registers apart. A run with the pair made equal then shows the suppression. The period mapping is run with one duty below the period, one equal to it and one beyond it. This separates the restore-on-period path from the duty actions and from the 0 %/100 % hold. Further runs free-wrap without clearing, use toggle fields with bit 3 set, stop and restart the counter, and swap modes mid-period. These separate the counter, load and action-decode paths.

// File: rtl/cmp_pwm_timer.sv
module cmp_pwm_timer #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         run,
  input  logic         mode,
  input  logic         clr_en,
  input  logic [1:0]   clr_sel,
  input  logic         wr_en,
  input  logic [2:0]   wr_addr,
  input  logic [W-1:0] wr_data,
  output logic [W-1:0] count,
  output logic [3:0]   pin
);

  localparam int NREG = 4;

  logic [W-1:0] cmp [NREG];
  logic [3:0]   ctl [NREG];
  logic         mode_q;
  logic [3:0]   hit, init_lvl, pin_nxt;
  logic         clr, load;

  function automatic logic act(input logic [1:0] a, input logic cur);
    case (a)
      2'b01:   return 1'b0;
      2'b10:   return 1'b1;
      2'b11:   return !cur;
      default: return cur;
    endcase
  endfunction

  always_comb
    for (int i = 0; i < NREG; i++) hit[i] = run && (count == cmp[i]);

  assign clr  = clr_en && hit[clr_sel];
  assign load = !run || (mode != mode_q);

  always_comb begin
    for (int i = 0; i < NREG; i++) begin
      if (!mode) init_lvl[i] = (i % 2 == 0) ? ctl[i][2] : 1'b0;
      else       init_lvl[i] = (2'(i) == clr_sel) ? 1'b0 : ctl[i][2];
    end
    pin_nxt = pin;
    if (load) begin
      pin_nxt = init_lvl;
    end else if (!mode) begin
      for (int k = 0; k < NREG; k += 2) begin
        if (cmp[k] != cmp[k+1]) begin
          if (hit[k])        pin_nxt[k] = act(ctl[k][1:0], pin[k]);
          else if (hit[k+1]) pin_nxt[k] = act(ctl[k+1][1:0], pin[k]);
        end
        pin_nxt[k+1] = 1'b0;
      end
    end else begin
      for (int i = 0; i < NREG; i++) begin
        if (2'(i) == clr_sel) pin_nxt[i] = 1'b0;
        else if (cmp[i] != cmp[clr_sel]) begin
          if (hit[clr_sel]) pin_nxt[i] = ctl[i][2];
          else if (hit[i])  pin_nxt[i] = act(ctl[i][1:0], pin[i]);
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      count  <= '0;
      pin    <= '0;
      mode_q <= 1'b0;
    end else begin
      if (run) count <= clr ? '0 : count + 1'b1;
      pin    <= pin_nxt;
      mode_q <= mode;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NREG; i++) begin
        cmp[i] <= '1;
        ctl[i] <= '0;
      end
    end else if (wr_en) begin
      if (!wr_addr[2]) cmp[wr_addr[1:0]] <= wr_data;
      else             ctl[wr_addr[1:0]] <= wr_data[3:0];
    end
  end

  a_r2_clear_to_zero: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (count == '0));

  a_r1_hold_when_stopped: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> $stable(count));

  a_r5_paired_odd_low: assert property (@(posedge clk) disable iff (!rst_n)
    !mode |=> (pin[1] == 1'b0 && pin[3] == 1'b0));

  a_r8_period_pin_low: assert property (@(posedge clk) disable iff (!rst_n)
    mode |=> !pin[$past(clr_sel)]);

  a_r9_pair_equal_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && !mode && cmp[0] == cmp[1]) |=> $stable(pin[0]));

  a_r10_stopped_init: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !mode) |=> (pin[0] == $past(ctl[0][2])));

endmodule

// File: tb/cmp_pwm_timer_test.sv
module cmp_pwm_timer_test;
  localparam int W = 8;
  localparam time TCLK = 10ns;

  logic clk = 1'b0, rst_n = 1'b0, run = 1'b0, mode = 1'b0, clr_en = 1'b0, wr_en = 1'b0;
  logic [1:0] clr_sel = 2'd0;
  logic [2:0] wr_addr = 3'd0;
  logic [W-1:0] wr_data = '0;
  logic [W-1:0] count;
  logic [3:0] pin;

  int compared = 0, mismatched = 0;
  bit done = 0;
  string cur_req = "R1 reset";

  int m_cnt, m_cmp[4], m_ctl[4], m_pin[4], m_mode_q;

  cmp_pwm_timer #(.W(W)) uut (
    .clk(clk), .rst_n(rst_n), .run(run), .mode(mode), .clr_en(clr_en),
    .clr_sel(clr_sel), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .count(count), .pin(pin));

  always #(TCLK/2) clk = ~clk;

  function automatic int do_act(int code, int lvl);
    if (code == 1) return 0;
    if (code == 2) return 1;
    if (code == 3) return 1 - lvl;
    return lvl;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_cnt = 0; m_mode_q = 0;
      for (int i = 0; i < 4; i++) begin m_cmp[i] = 255; m_ctl[i] = 0; m_pin[i] = 0; end
    end else begin
      int nxt[4];
      int per;
      bit eq[4];
      per = clr_sel;
      for (int i = 0; i < 4; i++) begin
        eq[i] = run && (m_cnt == m_cmp[i]);
        nxt[i] = m_pin[i];
      end
      if (!run || mode != m_mode_q) begin
        for (int i = 0; i < 4; i++) begin
          int ini;
          ini = (m_ctl[i] >> 2) & 1;
          if (mode == 0) nxt[i] = (i == 0 || i == 2) ? ini : 0;
          else nxt[i] = (i == per) ? 0 : ini;
        end
      end else if (mode == 0) begin
        foreach (nxt[lead]) if (lead == 0 || lead == 2) begin
          int trail;
          trail = lead + 1;
          if (m_cmp[lead] != m_cmp[trail]) begin
            if (eq[lead]) nxt[lead] = do_act(m_ctl[lead] & 3, m_pin[lead]);
            else if (eq[trail]) nxt[lead] = do_act(m_ctl[trail] & 3, m_pin[lead]);
          end
          nxt[trail] = 0;
        end
      end else begin
        for (int i = 0; i < 4; i++) begin
          if (i == per) nxt[i] = 0;
          else if (m_cmp[i] == m_cmp[per]) nxt[i] = m_pin[i];
          else if (eq[per]) nxt[i] = (m_ctl[i] >> 2) & 1;
          else if (eq[i]) nxt[i] = do_act(m_ctl[i] & 3, m_pin[i]);
        end
      end
      if (run) begin
        if (clr_en && eq[per]) m_cnt = 0;
        else m_cnt = (m_cnt + 1) % (1 << W);
      end
      for (int i = 0; i < 4; i++) m_pin[i] = nxt[i];
      m_mode_q = mode;
      if (wr_en) begin
        if (wr_addr[2]) m_ctl[wr_addr[1:0]] = int'(wr_data) & 15;
        else m_cmp[wr_addr[1:0]] = int'(wr_data);
      end
    end
  end

  always @(negedge clk) if (!done) begin
    logic [3:0] ep;
    ep = {m_pin[3][0], m_pin[2][0], m_pin[1][0], m_pin[0][0]};
    compared++;
    if (pin !== ep || int'(count) != m_cnt) begin
      mismatched++;
      $display("FAIL %s t=%0t pin act=%b exp=%b count act=%0d exp=%0d",
               cur_req, $time, pin, ep, count, m_cnt);
    end
  end

  task automatic wr(input int a, input int d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 3'(a); wr_data = W'(d);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      mismatched++; compared++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    idle(3);
    cur_req = "R1 reset state";
    @(negedge clk); rst_n = 1'b1;
    idle(4);
    cur_req = "R11 writes while stopped R10";
    wr(0, 10); wr(1, 40); wr(2, 20); wr(3, 99);
    wr(4, 4'b0010); wr(5, 4'b0001); wr(6, 4'b0111); wr(7, 4'b0011);
    @(negedge clk); clr_sel = 2'd3; clr_en = 1'b1; mode = 1'b0;
    idle(3);
    cur_req = "R4 R5 R2 paired mapping";
    run = 1'b1;
    idle(320);
    cur_req = "R1 R10 stop and restart";
    run = 1'b0; idle(10); run = 1'b1;
    idle(150);
    cur_req = "R9 paired equal values";
    wr(1, 10);
    idle(250);
    cur_req = "R10 R6 R7 R8 period mapping";
    wr(1, 10); wr(0, 50); wr(2, 30); wr(3, 60);
    wr(4, 4'b0000); wr(5, 4'b0101); wr(6, 4'b0010); wr(7, 4'b0101);
    @(negedge clk); clr_sel = 2'd0; mode = 1'b1;
    idle(260);
    cur_req = "R12 duty beyond period";
    wr(7, 4'b0110); wr(6, 4'b0001);
    idle(200);
    cur_req = "R9 duty equal to period";
    wr(3, 50);
    idle(200);
    cur_req = "R6 duty at zero R11";
    wr(2, 0); wr(6, 4'b0010);
    idle(200);
    cur_req = "R3 toggle with bit3 set";
    wr(5, 4'b1011); wr(6, 4'b1111);
    @(negedge clk); clr_sel = 2'd3; wr(3, 70);
    idle(300);
    cur_req = "R10 mode swap mid period";
    @(negedge clk); mode = 1'b0;
    idle(100);
    @(negedge clk); mode = 1'b1;
    idle(100);
    cur_req = "R1 free-running wrap";
    @(negedge clk); clr_en = 1'b0;
    idle(700);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule